// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel

This block is one DMA channel that copies a block of 16-bit or 32-bit units from a source address range to a destination address range. It uses a request/acknowledge memory port that carries one access at a time. Software programs a source register, a destination register and a 32-bit control word. Setting the enable bit in the control word (a 0-to-1 change) latches the working addresses. The channel then starts at once, or waits for a trigger pulse from a peripheral. Each address can count up, count down or stay fixed. The destination may instead be reloaded from its register every time a pass starts.

During a burst the channel holds a stall output high so that the processor keeps off the bus. Every access first waits for a number of cycles that depends on the 16 MB region it targets and on the unit size; only then does it raise its request. At the end of the whole count the channel spends two more cycles, then clears its enable unless repeat is set, and can pulse an interrupt. In the FIFO-feeding trigger mode a long transfer is cut into bursts of at most 112 units. The channel pauses between bursts and keeps its addresses and remaining count.

Top module: `dma_channel`

## Requirements
- R1: Working addresses are latched only when a control write changes bit 31 from 0 to 1. A control write made while bit 31 is already 1 leaves the working source and destination addresses and the remaining count unchanged, even after the source register has been rewritten.
- R2: Destination step mode, control bits 22:21: 00 counts up, 01 counts down, 10 stays fixed, 11 counts up and reloads the destination from its register at the start of every pass.
- R3: Source step mode, control bits 24:23: 00 counts up, 01 counts down, 10 stays fixed, 11 behaves as counting up.
- R4: Control bit 26 set selects 32-bit units with an address step of 4; clear selects 16-bit units with a step of 2, of which only the low 16 data bits are significant.
- R5: The unit count is the low CNT_W bits of the control word; a count of zero moves 2^CNT_W units.
- R6: Trigger mode in bits 29:27: 0 starts two cycles after the enabling write. Any other value waits for a trigger pulse. A trigger is ignored while bit 31 is clear and while a burst is running.
- R7: In trigger mode 7 each trigger moves at most 112 units. The channel then goes idle with its addresses and remaining count kept, and the stall output low.
- R8: After the last unit, bit 31 is cleared unless repeat bit 25 is set, and the interrupt output pulses high for one cycle if bit 30 is set.
- R9: Before each request, the access waits the wait-state count of its address region (bits 27:24). Region 2, 5 or 6 waits 1 cycle for 16-bit units and 2 for 32-bit units; region 8 or 9 waits 6 or 12; region A waits 10 for both sizes; every other region waits 1. Completion adds 2 stall cycles.
- R10: Each unit is one read of the source followed by one write of the read data to the destination. Each access holds its request until acknowledged.
- R11: The stall output is high from the start of a burst until its last unit (plus the completion cycles), and low otherwise; every request falls inside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control, 3 none |
| cfg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Current control word |
| trig | input | 1 | Start trigger pulse |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 32-bit |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access acknowledge |
| cpu_halt | output | 1 | Processor stall |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume that the memory raises its acknowledge only while a request is held. They also assume that software never writes the control word, and never re-arms the channel, while a burst is running. The stimulus keeps every register write inside idle windows. Its memory model answers each request after a fixed latency chosen for the pass and drops the acknowledge once the request falls. Trigger pulses sent during a burst test that they are ignored.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned WAIT_W = 4;

  // Control word field positions
  localparam int unsigned CB_EN      = 31;
  localparam int unsigned CB_IRQ     = 30;
  localparam int unsigned CB_MODE_LO = 27;
  localparam int unsigned CB_WIDE    = 26;
  localparam int unsigned CB_RPT     = 25;
  localparam int unsigned CB_SRC_LO  = 23;
  localparam int unsigned CB_DST_LO  = 21;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [1:0] STEP_DOWN  = 2'b01;
  localparam logic [1:0] STEP_HOLD  = 2'b10;
  localparam logic [1:0] STEP_RELD  = 2'b11;

  localparam logic [WAIT_W-1:0] FINISH_CYCLES = 4'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_RD,
    ST_WWAIT,
    ST_WR,
    ST_TAIL
  } seq_state_t;

  // Wait cycles before a request, per 16 MB region and unit size
  function automatic logic [WAIT_W-1:0] region_wait(input logic [3:0] region,
                                                    input logic       wide);
    case (region)
      4'h2, 4'h5, 4'h6: region_wait = wide ? 4'd2 : 4'd1;
      4'h8, 4'h9:       region_wait = wide ? 4'd12 : 4'd6;
      4'hA:             region_wait = 4'd10;
      default:          region_wait = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              done_clr,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [31:0]       ctrl_q,
  output logic              arm_q
);

  logic        src_we;
  logic        dst_we;
  logic        ctrl_we;
  logic        ctrl_en;
  logic [31:0] ctrl_d;
  logic        arm_d;

  always_comb begin
    src_we  = cfg_we && (cfg_sel == SEL_SRC);
    dst_we  = cfg_we && (cfg_sel == SEL_DST);
    ctrl_we = cfg_we && (cfg_sel == SEL_CTRL);
    ctrl_d  = ctrl_q;
    if (done_clr) ctrl_d[CB_EN] = 1'b0;
    if (ctrl_we)  ctrl_d = cfg_wdata;
    ctrl_en = ctrl_we || done_clr;
    arm_d   = ctrl_we && cfg_wdata[CB_EN] && !ctrl_q[CB_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      ctrl_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (src_we)  src_q  <= cfg_wdata[ADDR_W-1:0];
      if (dst_we)  dst_q  <= cfg_wdata[ADDR_W-1:0];
      if (ctrl_en) ctrl_q <= ctrl_d;
      arm_q <= arm_d;
    end
  end

  // R1
  arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> (ctrl_q[CB_EN] && !$past(ctrl_q[CB_EN])));

endmodule

// File: rtl/dma_ch_addr.sv
module dma_ch_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [1:0]        mode,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] BYTES_WIDE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BYTES_NARROW = ADDR_W'(2);

  logic [ADDR_W-1:0] unit_bytes;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    unit_bytes = wide ? BYTES_WIDE : BYTES_NARROW;
    case (mode)
      2'b01:   stepped = addr_q - unit_bytes;
      2'b10:   stepped = addr_q;
      default: stepped = addr_q + unit_bytes;
    endcase
    addr_d  = load ? load_val : stepped;
    addr_en = load || step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R2 R3
  hold_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode == 2'b10) |=> $stable(addr_q));

endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int unsigned       CNT_W     = 21,
  parameter int unsigned       BURST_MAX = 112,
  parameter logic [MODE_W-1:0] FIFO_MODE = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              en,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wide,
  input  logic              irq_en,
  input  logic              trig,
  input  logic [3:0]        src_region,
  input  logic [3:0]        dst_region,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              start_p,
  output logic              unit_done,
  output logic              fin_p,
  output logic              mem_req,
  output logic              mem_wr,
  output logic [DATA_W-1:0] data_q,
  output logic              irq,
  output logic              halt
);

  localparam int unsigned      REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL  = {1'b1, {CNT_W{1'b0}}};
  localparam logic [REM_W-1:0] CAP   = REM_W'(BURST_MAX);
  localparam logic [REM_W-1:0] ONE   = REM_W'(1);

  seq_state_t        st_q, st_d;
  logic [WAIT_W-1:0] wt_q, wt_d, wt_inc;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [REM_W-1:0]  bur_q, bur_d;
  logic [REM_W-1:0]  pass_len, burst_len;
  logic              inprog_q, inprog_d;
  logic              go_q, go_d;
  logic [DATA_W-1:0] data_d;
  logic              irq_d;
  logic [WAIT_W-1:0] src_ws, dst_ws;

  always_comb begin
    src_ws    = region_wait(src_region, wide);
    dst_ws    = region_wait(dst_region, wide);
    wt_inc    = wt_q + WAIT_W'(1);
    pass_len  = inprog_q ? rem_q : ((cnt == '0) ? FULL : {1'b0, cnt});
    burst_len = ((trig_mode == FIFO_MODE) && (pass_len > CAP)) ? CAP : pass_len;
    start_p   = (st_q == ST_IDLE) && en && !arm &&
                (go_q || ((trig_mode != '0) && trig));
  end

  always_comb begin
    st_d      = st_q;
    wt_d      = wt_q;
    rem_d     = rem_q;
    bur_d     = bur_q;
    inprog_d  = inprog_q;
    go_d      = go_q;
    data_d    = data_q;
    unit_done = 1'b0;
    fin_p     = 1'b0;
    if (arm) begin
      go_d     = (trig_mode == '0);
      inprog_d = 1'b0;
    end
    case (st_q)
      ST_IDLE: begin
        if (start_p) begin
          st_d     = ST_RWAIT;
          wt_d     = '0;
          rem_d    = pass_len;
          bur_d    = burst_len;
          inprog_d = 1'b1;
          go_d     = 1'b0;
        end
      end
      ST_RWAIT: begin
        if (wt_inc >= src_ws) st_d = ST_RD;
        else wt_d = wt_inc;
      end
      ST_RD: begin
        if (mem_ack) begin
          data_d = mem_rdata;
          wt_d   = '0;
          st_d   = ST_WWAIT;
        end
      end
      ST_WWAIT: begin
        if (wt_inc >= dst_ws) st_d = ST_WR;
        else wt_d = wt_inc;
      end
      ST_WR: begin
        if (mem_ack) begin
          unit_done = 1'b1;
          rem_d     = rem_q - ONE;
          bur_d     = bur_q - ONE;
          wt_d      = '0;
          if (bur_q == ONE) st_d = (rem_q == ONE) ? ST_TAIL : ST_IDLE;
          else st_d = ST_RWAIT;
        end
      end
      ST_TAIL: begin
        if (wt_inc >= FINISH_CYCLES) begin
          st_d     = ST_IDLE;
          fin_p    = 1'b1;
          inprog_d = 1'b0;
        end else begin
          wt_d = wt_inc;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    irq_d = fin_p && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wt_q     <= '0;
      rem_q    <= '0;
      bur_q    <= '0;
      inprog_q <= 1'b0;
      go_q     <= 1'b0;
      data_q   <= '0;
      irq      <= 1'b0;
    end else begin
      st_q     <= st_d;
      wt_q     <= wt_d;
      rem_q    <= rem_d;
      bur_q    <= bur_d;
      inprog_q <= inprog_d;
      go_q     <= go_d;
      data_q   <= data_d;
      irq      <= irq_d;
    end
  end

  always_comb begin
    mem_req = (st_q == ST_RD) || (st_q == ST_WR);
    mem_wr  = (st_q == ST_WR);
    halt    = (st_q != ST_IDLE);
  end

  // R11
  req_inside_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> halt);

  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && trig_mode == FIFO_MODE) |-> (bur_q <= CAP));

  // R5
  burst_within_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && st_q != ST_TAIL) |-> (bur_q != '0 && bur_q <= rem_q));

  // R10
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> ($past(st_q) == ST_WWAIT));

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       CNT_W     = 21,
  parameter int unsigned       BURST_MAX = 112,
  parameter logic [MODE_W-1:0] FIFO_MODE = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       ctrl_rd,
  input  logic              trig,
  output logic              mem_req,
  output logic              mem_wr,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              cpu_halt,
  output logic              irq
);

  logic [ADDR_W-1:0] src_reg, dst_reg;
  logic [ADDR_W-1:0] cur_src, cur_dst;
  logic [31:0]       ctrl_q;
  logic              arm_q;
  logic              start_p, unit_done, fin_p;
  logic              dst_load;
  logic [1:0]        src_mode, dst_mode;

  assign src_mode = ctrl_q[CB_SRC_LO+1:CB_SRC_LO];
  assign dst_mode = ctrl_q[CB_DST_LO+1:CB_DST_LO];
  assign dst_load = arm_q || (start_p && dst_mode == STEP_RELD);

  dma_ch_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .done_clr  (fin_p && !ctrl_q[CB_RPT]),
    .src_q     (src_reg),
    .dst_q     (dst_reg),
    .ctrl_q    (ctrl_q),
    .arm_q     (arm_q)
  );

  dma_ch_addr #(.ADDR_W(ADDR_W)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm_q),
    .load_val (src_reg),
    .step     (unit_done),
    .mode     (src_mode),
    .wide     (ctrl_q[CB_WIDE]),
    .addr_q   (cur_src)
  );

  dma_ch_addr #(.ADDR_W(ADDR_W)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dst_load),
    .load_val (dst_reg),
    .step     (unit_done),
    .mode     (dst_mode),
    .wide     (ctrl_q[CB_WIDE]),
    .addr_q   (cur_dst)
  );

  dma_ch_seq #(
    .CNT_W     (CNT_W),
    .BURST_MAX (BURST_MAX),
    .FIFO_MODE (FIFO_MODE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm_q),
    .en         (ctrl_q[CB_EN]),
    .trig_mode  (ctrl_q[CB_MODE_LO+MODE_W-1:CB_MODE_LO]),
    .cnt        (ctrl_q[CNT_W-1:0]),
    .wide       (ctrl_q[CB_WIDE]),
    .irq_en     (ctrl_q[CB_IRQ]),
    .trig       (trig),
    .src_region (cur_src[27:24]),
    .dst_region (cur_dst[27:24]),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .start_p    (start_p),
    .unit_done  (unit_done),
    .fin_p      (fin_p),
    .mem_req    (mem_req),
    .mem_wr     (mem_wr),
    .data_q     (mem_wdata),
    .irq        (irq),
    .halt       (cpu_halt)
  );

  assign mem_addr = mem_wr ? cur_dst : cur_src;
  assign mem_wide = ctrl_q[CB_WIDE];
  assign ctrl_rd  = ctrl_q;

endmodule

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
module dma_channel_test;

  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] ctrl_rd;
  logic        trig;
  logic        mem_req, mem_wr, mem_wide;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        cpu_halt, irq;

  always #2 clk = ~clk;

  dma_channel #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd), .trig(trig),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .cpu_halt(cpu_halt), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int hold = 0;
  int n_got = 0, n_exp = 0;
  int halt_cnt = 0, irq_cnt = 0, exp_cost = 0;
  logic [31:0] got_a [0:511];
  logic [31:0] got_d [0:511];
  logic [31:0] exp_a [0:511];
  logic [31:0] exp_d [0:511];
  logic [31:0] m_src, m_dst;
  logic [1:0]  m_sm, m_dm;
  logic        m_w;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h6B29};
  endfunction

  function automatic int wsf(input logic [3:0] r, input logic w);
    case (r)
      4'h2, 4'h5, 4'h6: return w ? 2 : 1;
      4'h8, 4'h9:       return w ? 12 : 6;
      4'hA:             return 10;
      default:          return 1;
    endcase
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] m,
                                      input logic w);
    case (m)
      2'b01:   return a - (w ? 32'd4 : 32'd2);
      2'b10:   return a;
      default: return a + (w ? 32'd4 : 32'd2);
    endcase
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic en, input logic ie,
      input logic [2:0] md, input logic w, input logic rp,
      input logic [1:0] sm, input logic [1:0] dm, input logic [7:0] c);
    return {en, ie, md, w, rp, sm, dm, 13'd0, c};
  endfunction

  function automatic logic [3:0] pick_region(input int k);
    case (k % 6)
      0: return 4'h2;
      1: return 4'h3;
      2: return 4'h5;
      3: return 4'h8;
      4: return 4'hA;
      default: return 4'h6;
    endcase
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Memory model and observers
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (cpu_halt) halt_cnt++;
      if (irq) irq_cnt++;
      if (mem_req) begin
        if (hold == lat) begin
          mem_ack = 1'b1;
          hold = 0;
          mem_rdata = pat(mem_addr);
          if (mem_wr) begin
            got_a[n_got] = mem_addr;
            got_d[n_got] = mem_wdata;
            if (n_got < 511) n_got++;
          end
        end else begin
          mem_ack = 1'b0;
          hold++;
        end
      end else begin
        mem_ack = 1'b0;
        hold = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic clear_obs();
    n_got = 0; halt_cnt = 0; irq_cnt = 0; n_exp = 0; exp_cost = 0;
  endtask

  task automatic wait_run();
    int t;
    t = 0;
    while (!cpu_halt && t < 200) begin @(negedge clk); t++; end
    t = 0;
    while (cpu_halt && t < 30000) begin @(negedge clk); t++; end
    if (t >= 30000) chk("run timeout", 1, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic model_units(input int n);
    for (int i = 0; i < n; i++) begin
      exp_a[n_exp] = m_dst;
      exp_d[n_exp] = pat(m_src);
      exp_cost += wsf(m_src[27:24], m_w) + wsf(m_dst[27:24], m_w) + 2 * (lat + 1);
      n_exp++;
      m_src = nxt(m_src, m_sm, m_w);
      m_dst = nxt(m_dst, m_dm, m_w);
    end
  endtask

  task automatic compare(input string tag, input int tail);
    int bad;
    logic [31:0] mask;
    bad = 0;
    mask = m_w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    chk({tag, " unit count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      if (got_a[i] !== exp_a[i] || (got_d[i] & mask) !== (exp_d[i] & mask)) begin
        if (bad == 0)
          $display("  first mismatch unit %0d: addr %h/%h data %h/%h", i,
                   got_a[i], exp_a[i], got_d[i], exp_d[i]);
        bad++;
      end
    end
    chk({tag, " R10 write stream mismatches"}, bad, 0);
    chk({tag, " R9 stall cycles"}, halt_cnt, exp_cost + tail);
  endtask

  initial begin
    logic [31:0] s, d, c;
    int n;
    logic ie, rp;
    int seed;
    seed = 7;
    s = $urandom(seed);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset halt", cpu_halt, 0);
    chk("R10 reset req", mem_req, 0);
    chk("R8 reset irq", irq, 0);
    chk("R1 reset control", ctrl_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Random immediate passes: R2 R3 R4 R8 R9 R10 R11
    for (int it = 0; it < 24; it++) begin
      s = {4'h0, pick_region($urandom), 12'h0, (12'h400 + 12'($urandom % 2048)) & 12'hFFC};
      d = {4'h0, pick_region($urandom), 12'h0, (12'h400 + 12'($urandom % 2048)) & 12'hFFC};
      n = 1 + ($urandom % 20);
      m_sm = 2'($urandom); m_dm = 2'($urandom); m_w = 1'($urandom);
      ie = 1'($urandom); rp = 1'($urandom);
      lat = $urandom % 3;
      c = mk_ctrl(1'b0, ie, 3'd0, m_w, rp, m_sm, m_dm, 8'(n));
      cfg_wr(2'd0, s);
      cfg_wr(2'd1, d);
      cfg_wr(2'd2, c);
      m_src = s; m_dst = d;
      clear_obs();
      c[31] = 1'b1;
      cfg_wr(2'd2, c);
      wait_run();
      model_units(n);
      compare($sformatf("R2 R3 R4 random pass %0d", it), 2);
      chk("R8 irq pulses", irq_cnt, ie);
      chk("R8 enable after completion", ctrl_rd[31], rp);
    end

    // R5 zero count moves 2^CW units, 32-bit, fixed source, falling destination
    lat = 1;
    m_sm = 2'b10; m_dm = 2'b01; m_w = 1'b1;
    s = 32'h0200_0100; d = 32'h0300_0C00;
    cfg_wr(2'd0, s); cfg_wr(2'd1, d);
    cfg_wr(2'd2, mk_ctrl(1'b0, 1'b1, 3'd0, 1'b1, 1'b0, m_sm, m_dm, 8'd0));
    m_src = s; m_dst = d;
    clear_obs();
    cfg_wr(2'd2, mk_ctrl(1'b1, 1'b1, 3'd0, 1'b1, 1'b0, m_sm, m_dm, 8'd0));
    wait_run();
    model_units(256);
    compare("R5 zero count", 2);
    chk("R5 irq", irq_cnt, 1);

    // R7 and R1: FIFO trigger mode with 250 units in three bursts
    lat = 0;
    m_sm = 2'b00; m_dm = 2'b00; m_w = 1'b0;
    s = 32'h0200_0400; d = 32'h0500_0400;
    cfg_wr(2'd0, s); cfg_wr(2'd1, d);
    c = mk_ctrl(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, m_sm, m_dm, 8'd250);
    cfg_wr(2'd2, c);
    m_src = s; m_dst = d;
    clear_obs();
    c[31] = 1'b1;
    cfg_wr(2'd2, c);
    repeat (10) @(negedge clk);
    chk("R6 waits for trigger", halt_cnt, 0);
    trig_pulse();
    wait_run();
    model_units(112);
    compare("R7 first burst", 0);
    chk("R7 no irq on pause", irq_cnt, 0);
    chk("R7 still enabled", ctrl_rd[31], 1);
    chk("R7 halt low on pause", cpu_halt, 0);
    cfg_wr(2'd0, 32'h0800_1000);
    cfg_wr(2'd2, c);
    clear_obs();
    trig_pulse();
    wait_run();
    model_units(112);
    compare("R1 rewrite while set keeps addresses", 0);
    clear_obs();
    trig_pulse();
    wait_run();
    model_units(26);
    compare("R7 final burst", 2);
    chk("R8 irq after final burst", irq_cnt, 1);
    chk("R8 enable cleared", ctrl_rd[31], 0);

    // R6 trigger ignored while disabled
    lat = 2;
    m_sm = 2'b11; m_dm = 2'b11; m_w = 1'b1;
    s = 32'h0600_0200; d = 32'h0900_0300;
    cfg_wr(2'd0, s); cfg_wr(2'd1, d);
    c = mk_ctrl(1'b0, 1'b0, 3'd1, 1'b1, 1'b1, m_sm, m_dm, 8'd6);
    cfg_wr(2'd2, c);
    clear_obs();
    trig_pulse();
    repeat (20) @(negedge clk);
    chk("R6 disabled trigger writes", n_got, 0);
    chk("R6 disabled trigger stall", halt_cnt, 0);
    c[31] = 1'b1;
    cfg_wr(2'd2, c);
    repeat (20) @(negedge clk);
    chk("R6 armed idle without trigger", halt_cnt, 0);
    m_src = s; m_dst = d;
    clear_obs();
    trig_pulse();
    while (!cpu_halt) @(negedge clk);
    repeat (3) @(negedge clk);
    trig_pulse();
    begin
      int t;
      t = 0;
      while (cpu_halt && t < 30000) begin @(negedge clk); t++; end
    end
    repeat (40) @(negedge clk);
    model_units(6);
    compare("R6 busy trigger ignored", 2);
    chk("R8 repeat keeps enable", ctrl_rd[31], 1);
    chk("R8 no irq when disabled", irq_cnt, 0);

    // R2 destination reload on restart, source continues
    d = 32'h0300_0200;
    cfg_wr(2'd1, d);
    m_dst = d;
    clear_obs();
    trig_pulse();
    wait_run();
    model_units(6);
    compare("R2 reload on repeat", 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule